// File: doc/BRIEF.md
# Storage-Section Line Transfer Sequencer

This block generates the four storage-section phase levels that shift one line of charge into a CCD output register while the horizontal register clocks are stopped during line blanking. The phases walk through a cyclic eight-state pattern. Every state keeps each phase high for five of the eight states, and neighbouring phases overlap by three states. Four consecutive states make one line shift, so the full eight-state cycle shifts two lines. Successive transfers therefore start alternately from the first and the second half of the pattern.

Each state is held for N master clocks. N is the horizontal pixel rate divided by eight times the vertical transfer rate; for example, 18 MHz against 450 kHz gives N = 5. A transfer starts when a request is seen while the block is idle. N is captured at that moment. When the fourth state has run out, the block emits a one-cycle done pulse that lets the horizontal generator restart, and a black-level clamp pulse that lasts N cycles. A camera timing controller issues one request per line period inside the blanking interval. A full frame readout takes 1030 requests: 1024 active lines and 6 black lines.

Top module: `vxfer_seq`

## Requirements
- R1: While reset is high, and in the first cycle after it, phase_o equals the pattern of state 0 (4'b1101), and done_o and clamp_o are 0.
- R2: Bit k of phase_o is high in state s exactly when (s - 2k) mod 8 is below 5. This gives, for states 0 to 7, phase_o = 1101, 1001, 1011, 0011, 0111, 0110, 1110, 1100 (bit 3 leftmost).
- R3: An accepted request advances the state index by exactly four, wrapping modulo 8, one state at a time. Between transfers phase_o holds the final state.
- R4: Each state lasts N cycles. N is sampled from div_n at the edge that accepts the request, and a later change of div_n has no effect on that transfer. The first new state appears in the cycle after the accepting edge.
- R5: div_n = 0 is treated as N = 1.
- R6: A request seen at a clock edge while a transfer is in progress is ignored, including the edge that ends the transfer.
- R7: done_o is high for exactly one cycle, the cycle that starts 4N edges after the accepting edge. phase_o does not change in that cycle.
- R8: clamp_o rises together with done_o and stays high for N cycles, where N belongs to the transfer that just ended. A new done restarts the clamp with its own N.
- R9: A request seen at the edge that ends the done cycle is accepted, so transfers can run back to back with one idle cycle between them.
- R10: From one cycle to the next, at most one phase changes, and in every cycle two or three phases are high.

Top module ports, in port-list order:

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| xfer_req | input | 1 | Line transfer request, sampled each edge |
| div_n | input | DIV_W (4) | Master clocks per state; 0 acts as 1 |
| phase_o | output | 4 | Storage phase levels, bit k = phase k |
| clamp_o | output | 1 | Black-level clamp pulse |
| done_o | output | 1 | One-cycle end-of-transfer pulse |

## Verification
The end of one transfer and the start of the next can fall close together. The done pulse, the running clamp window and a fresh acceptance can all meet at the done cycle, and a short transfer can finish while a long clamp from the previous line is still active. The bench provokes both cases. It holds the request high across a whole transfer so that it is accepted in the cycle right after done, and it follows an N = 15 transfer with an N = 1 transfer so that the clamp is restarted. A per-cycle reference trace, built from the request edges and the latched N, judges each output cycle by cycle.

// File: rtl/vxfer_pkg.sv
package vxfer_pkg;
  localparam int VX_PHASES = 4;   // storage phases
  localparam int VX_STATES = 8;   // states in one full pattern cycle (power of two)
  localparam int VX_HIGH   = 5;   // states each phase stays high
  localparam int VX_SHIFT  = 2;   // state offset between neighbouring phases
  localparam int VX_STEPS  = 4;   // states per line shift
  localparam int VX_STW    = $clog2(VX_STATES);
  localparam int VX_SPW    = $clog2(VX_STEPS);

  typedef logic [VX_STW-1:0] vx_state_t;
endpackage

// File: rtl/vxfer_ctrl.sv
module vxfer_ctrl #(
  parameter int DIV_W = 4,
  parameter int STEPS = vxfer_pkg::VX_STEPS,
  localparam int SPW  = (STEPS > 1) ? $clog2(STEPS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req,
  input  logic [DIV_W-1:0] div_n,
  output logic             adv,
  output logic             fin,
  output logic [DIV_W-1:0] n_held
);
  localparam logic [SPW-1:0] LAST = SPW'(STEPS - 1);

  logic             busy;
  logic [DIV_W-1:0] cnt;
  logic [SPW-1:0]   step;
  logic [DIV_W-1:0] n_eff;
  logic             start;
  logic             expire;

  assign n_eff  = (div_n == '0) ? DIV_W'(1) : div_n;
  assign start  = req & ~busy;
  assign expire = busy & (cnt == '0);
  assign adv    = start | (expire & (step != LAST));
  assign fin    = expire & (step == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      cnt    <= '0;
      step   <= '0;
      n_held <= DIV_W'(1);
    end else if (start) begin
      busy   <= 1'b1;
      n_held <= n_eff;
      cnt    <= n_eff - DIV_W'(1);
      step   <= '0;
    end else if (busy) begin
      if (cnt == '0) begin
        if (step == LAST) begin
          busy <= 1'b0;
        end else begin
          step <= step + SPW'(1);
          cnt  <= n_held - DIV_W'(1);
        end
      end else begin
        cnt <= cnt - DIV_W'(1);
      end
    end
  end
endmodule

// File: rtl/vxfer_phase_gen.sv
module vxfer_phase_gen #(
  parameter int NP     = vxfer_pkg::VX_PHASES,
  parameter int STATES = vxfer_pkg::VX_STATES,
  parameter int HIGH   = vxfer_pkg::VX_HIGH,
  parameter int SHIFT  = vxfer_pkg::VX_SHIFT,
  localparam int STW   = $clog2(STATES)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv,
  output logic [NP-1:0] phase
);
  logic [STW-1:0] pos_q;
  logic [STW-1:0] pos_nxt;
  logic [NP-1:0]  lvl_nxt;
  logic [NP-1:0]  lvl_rst;

  assign pos_nxt = adv ? pos_q + STW'(1) : pos_q;

  for (genvar k = 0; k < NP; k++) begin : g_phase
    localparam logic [STW-1:0] OFS = STW'((k * SHIFT) % STATES);
    logic [STW-1:0] rel_run;
    logic [STW-1:0] rel_zero;
    assign rel_run    = pos_nxt - OFS;
    assign rel_zero   = '0 - OFS;
    assign lvl_nxt[k] = ({1'b0, rel_run}  < (STW+1)'(HIGH));
    assign lvl_rst[k] = ({1'b0, rel_zero} < (STW+1)'(HIGH));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q <= '0;
      phase <= lvl_rst;
    end else begin
      pos_q <= pos_nxt;
      phase <= lvl_nxt;
    end
  end
endmodule

// File: rtl/vxfer_clamp.sv
module vxfer_clamp #(
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fin,
  input  logic [DIV_W-1:0] n_held,
  output logic             done,
  output logic             clamp
);
  logic [DIV_W-1:0] left;

  always_ff @(posedge clk) begin
    if (rst) begin
      done  <= 1'b0;
      clamp <= 1'b0;
      left  <= '0;
    end else begin
      done <= fin;
      if (fin) begin
        clamp <= 1'b1;
        left  <= n_held - DIV_W'(1);
      end else if (clamp) begin
        if (left == '0) clamp <= 1'b0;
        else            left  <= left - DIV_W'(1);
      end
    end
  end
endmodule

// File: rtl/vxfer_seq.sv
module vxfer_seq #(
  parameter int DIV_W      = 4,
  parameter int NUM_PHASES = vxfer_pkg::VX_PHASES
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  xfer_req,
  input  logic [DIV_W-1:0]      div_n,
  output logic [NUM_PHASES-1:0] phase_o,
  output logic                  clamp_o,
  output logic                  done_o
);
  logic             adv;
  logic             fin;
  logic [DIV_W-1:0] n_held;

  vxfer_ctrl #(.DIV_W(DIV_W), .STEPS(vxfer_pkg::VX_STEPS)) u_ctrl (
    .clk(clk), .rst(rst), .req(xfer_req), .div_n(div_n),
    .adv(adv), .fin(fin), .n_held(n_held)
  );

  vxfer_phase_gen #(
    .NP(NUM_PHASES), .STATES(vxfer_pkg::VX_STATES),
    .HIGH(vxfer_pkg::VX_HIGH), .SHIFT(vxfer_pkg::VX_SHIFT)
  ) u_phase (
    .clk(clk), .rst(rst), .adv(adv), .phase(phase_o)
  );

  vxfer_clamp #(.DIV_W(DIV_W)) u_clamp (
    .clk(clk), .rst(rst), .fin(fin), .n_held(n_held),
    .done(done_o), .clamp(clamp_o)
  );
endmodule

// File: rtl/vxfer_seq_chk.sv
module vxfer_seq_chk #(
  parameter int NP = vxfer_pkg::VX_PHASES
) (
  input logic          clk,
  input logic          rst,
  input logic [NP-1:0] phase_o,
  input logic          done_o,
  input logic          clamp_o
);
  localparam int LO = (vxfer_pkg::VX_HIGH * NP) / vxfer_pkg::VX_STATES;
  localparam int HI = LO + 1;

  AST_ONE_PHASE_STEP: assert property (@(posedge clk) disable iff (rst)
    $countones(phase_o ^ $past(phase_o)) <= 1); // R10

  AST_PHASE_COUNT: assert property (@(posedge clk) disable iff (rst)
    ($countones(phase_o) >= LO) && ($countones(phase_o) <= HI)); // R10

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o); // R7

  AST_DONE_STILL: assert property (@(posedge clk) disable iff (rst)
    done_o |-> $stable(phase_o)); // R7

  AST_CLAMP_START: assert property (@(posedge clk) disable iff (rst)
    $rose(clamp_o) |-> done_o); // R8
endmodule

bind vxfer_seq vxfer_seq_chk #(.NP(NUM_PHASES)) u_chk (
  .clk(clk), .rst(rst), .phase_o(phase_o), .done_o(done_o), .clamp_o(clamp_o)
);

// File: tb/sim_vxfer_seq.sv
`timescale 1ns/1ps
module sim_vxfer_seq;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       xfer_req = 1'b0;
  logic [3:0] div_n = 4'd1;
  logic [3:0] phase_o;
  logic       clamp_o;
  logic       done_o;

  always #10 clk = ~clk;

  vxfer_seq u0 (
    .clk(clk), .rst(rst), .xfer_req(xfer_req), .div_n(div_n),
    .phase_o(phase_o), .clamp_o(clamp_o), .done_o(done_o)
  );

  typedef struct {
    logic [3:0] ph;
    logic       dn;
    logic       cl;
    string      tag;
  } exp_t;

  exp_t  sb[$];
  int    n_chk = 0;
  int    n_bad = 0;
  string cur_tag = "R1";
  bit    ended = 0;

  // R2 pattern, state 0..7
  function automatic logic [3:0] pat(input int s);
    case (s)
      0: return 4'b1101;  1: return 4'b1001;
      2: return 4'b1011;  3: return 4'b0011;
      4: return 4'b0111;  5: return 4'b0110;
      6: return 4'b1110;  default: return 4'b1100;
    endcase
  endfunction

  // reference trace from requirements
  int cyc = 0;
  bit m_busy = 0;
  int m_e, m_n, m_base;
  int m_pos = 0;
  int m_clamp_last = -1;
  always @(posedge clk) begin
    exp_t it;
    int st;
    bit d;
    cyc++;
    if (!rst) begin
      d = 0;
      if (m_busy && cyc == m_e + 4 * m_n) begin
        m_busy = 0;
        m_pos = (m_base + 4) % 8;
        d = 1;
        m_clamp_last = cyc + m_n - 1;
      end else if (!m_busy && xfer_req) begin
        m_busy = 1;
        m_e = cyc;
        m_n = (div_n == 0) ? 1 : int'(div_n);
        m_base = m_pos;
      end
      st = m_busy ? (m_base + (cyc - m_e) / m_n + 1) % 8 : m_pos;
      it.ph = pat(st);
      it.dn = d;
      it.cl = (cyc <= m_clamp_last);
      it.tag = cur_tag;
      sb.push_back(it);
    end
  end

  logic [3:0] prev_ph;
  bit have_prev = 0;
  always @(negedge clk) begin
    exp_t e;
    if (sb.size() > 0) begin
      e = sb.pop_front();
      n_chk++;
      if (phase_o !== e.ph || done_o !== e.dn || clamp_o !== e.cl) begin
        n_bad++;
        $display("FAIL %s: phase=%b done=%b clamp=%b expected phase=%b done=%b clamp=%b",
                 e.tag, phase_o, done_o, clamp_o, e.ph, e.dn, e.cl);
      end
      if (have_prev) begin
        n_chk++;
        if ($countones(phase_o ^ prev_ph) > 1) begin
          n_bad++;
          $display("FAIL R10: phase step %b -> %b expected at most one bit change",
                   prev_ph, phase_o);
        end
      end
      prev_ph = phase_o;
      have_prev = 1;
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic request(input logic [3:0] n, input int hold);
    div_n = n;
    xfer_req = 1'b1;
    idle(hold);
    xfer_req = 1'b0;
  endtask

  task automatic finish_run;
    if (!ended) begin
      ended = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    idle(3);
    n_chk++;  // R1 reset state
    if (phase_o !== 4'b1101 || done_o !== 1'b0 || clamp_o !== 1'b0) begin
      n_bad++;
      $display("FAIL R1: phase=%b done=%b clamp=%b expected phase=1101 done=0 clamp=0",
               phase_o, done_o, clamp_o);
    end
    rst = 1'b0;
    idle(3);
    cur_tag = "R4"; request(4'd5, 1); idle(30);
    cur_tag = "R3"; request(4'd3, 1); idle(20);
    cur_tag = "R5"; request(4'd0, 1); idle(10);
    cur_tag = "R6"; request(4'd3, 8); idle(15);
    cur_tag = "R9"; request(4'd2, 10); idle(15);
    cur_tag = "R8"; request(4'd15, 1); idle(60);
    request(4'd1, 1); idle(25);
    cur_tag = "R4"; request(4'd6, 1); idle(3); div_n = 4'd2; idle(30);
    cur_tag = "R7"; request(4'd1, 1); idle(8);
    cur_tag = "R2"; request(4'd4, 1); idle(20);
    request(4'd7, 1); idle(35);
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not end, expected completion");
    finish_run();
  end
endmodule